// File: doc/BRIEF.md
# PWM time-base counter

This block provides the timing reference for one PWM channel. A prescaler divides the module clock by a power of two and produces a count tick. On each tick a 16-bit counter steps against an active period value. The counter can step upward and wrap, step downward and reload, or sweep up and then down in a triangle. An asymmetric waveform uses one of the first two modes. A symmetric waveform uses the triangle.

A neighbouring channel, or software, can resynchronise the counter. A hardware sync pin or a software strobe loads a phase value into the counter, and a configured direction then applies to the triangle mode. The period value is double-buffered: new values are written to a shadow register. A load-mode field decides when the shadow value is copied to the active register: at once, at every zero crossing, once after an arm strobe, or never.

The block outputs the counter value, its direction, one-cycle pulses when the counter reaches zero and when it reaches the period, and a selectable sync output for chaining channels.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, `dir_up` is 1, `zero_evt`, `prd_evt` and `sync_out` are 0, and the active and shadow periods equal `RESET_PERIOD`. The counter is stopped while `mode` is 3.
- R2: With `mode` = 0 (up) the counter steps 0, 1, ..., P and then returns to 0 on the next tick, where P is the active period. `zero_evt` is high for exactly one clock when a step lands on 0. `prd_evt` is high for exactly one clock when a step lands on P.
- R3: With `mode` = 1 (down) the counter steps downward, reloads P on the tick after it holds 0, and `dir_up` reads 0.
- R4: With `mode` = 2 (up-down) the counter climbs to P and then descends to 0, giving a cycle of 2P ticks. `dir_up` is 1 while climbing, turns 0 on the step away from P, and turns 1 on the step away from 0. A period of 0 holds the count at 0.
- R5: `prescale` = n makes the counter step once every 2^n clocks, and the count holds between ticks.
- R6: When `sync_en` is 1 and either `sync_in` or `sync_sw` is high at a clock edge, the count takes `phase` at that edge. This load has priority over a tick, and the prescaler restarts, so the next step comes 2^n clocks later.
- R7: In up-down mode a sync load sets `dir_up` to `sync_dir` (1 = up), and counting continues in that direction.
- R8: `sync_out` selects by `sync_sel`: 0 gives constant 0, 1 gives `sync_in` OR `sync_sw` combinationally, 2 gives `zero_evt`, and 3 gives `prd_evt`.
- R9: With `ld_mode` = 0, a `prd_wr` updates the active and shadow periods at the same edge.
- R10: With `ld_mode` = 1, a `prd_wr` updates only the shadow period. The shadow is copied to the active period on each step that lands on 0.
- R11: With `ld_mode` = 2, the shadow is copied only on the first zero-landing step after an `oneshot_arm` strobe, and later zeros leave the period alone until the next arm.
- R12: With `ld_mode` = 3, the shadow is never copied.
- R13: With `sync_en` = 0, sync pulses leave the counter running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 up, 1 down, 2 up-down, 3 stopped |
| prescale | input | PSW | Tick divider exponent, divide by 2^prescale |
| prd_wr | input | 1 | Period write strobe |
| prd_data | input | CW | Period write value |
| ld_mode | input | 2 | 0 immediate, 1 at zero, 2 one-shot at zero, 3 frozen |
| oneshot_arm | input | 1 | Arms one shadow-to-active copy |
| sync_en | input | 1 | Enables the phase load on sync |
| sync_in | input | 1 | Hardware sync input |
| sync_sw | input | 1 | Software sync strobe |
| phase | input | CW | Value loaded on sync |
| sync_dir | input | 1 | Direction after sync in up-down mode |
| sync_sel | input | 2 | Sync output source select |
| count | output | CW | Counter value |
| dir_up | output | 1 | 1 while counting up |
| zero_evt | output | 1 | One-clock pulse on landing at 0 |
| prd_evt | output | 1 | One-clock pulse on landing at the period |
| sync_out | output | 1 | Selected sync output |

## Verification
The count, the direction and both event pulses are registered. With prescale 0 they change at the first rising edge after an input change, and with prescale n they change at every 2^n-th edge. A sync load or a period write takes effect at the very edge on which it is sampled, while a shadow copy shows only on the steps after the zero landing. The pass-through sync output is combinational, so it is checked one nanosecond after the input moves. The bench drives every input on a falling edge and samples on a later falling edge, and it counts the rising edges in between to predict each value.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16,
  parameter int PSW = 3,
  parameter logic [CW-1:0] RESET_PERIOD = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic [PSW-1:0] prescale,
  input  logic           prd_wr,
  input  logic [CW-1:0]  prd_data,
  input  logic [1:0]     ld_mode,
  input  logic           oneshot_arm,
  input  logic           sync_en,
  input  logic           sync_in,
  input  logic           sync_sw,
  input  logic [CW-1:0]  phase,
  input  logic           sync_dir,
  input  logic [1:0]     sync_sel,
  output logic [CW-1:0]  count,
  output logic           dir_up,
  output logic           zero_evt,
  output logic           prd_evt,
  output logic           sync_out
);
  localparam int DIVW = (1 << PSW) - 1;
  localparam logic [1:0] M_UP = 2'd0, M_DN = 2'd1, M_UD = 2'd2, M_STOP = 2'd3;
  localparam logic [1:0] L_IMM = 2'd0, L_ZERO = 2'd1, L_ONCE = 2'd2;

  logic [DIVW-1:0] pre_q, pre_lim;
  logic [CW-1:0]   cnt_q, per_q, shd_q, nxt;
  logic            up_q, nxt_up, arm_q, zev_q, pev_q;

  wire running = mode != M_STOP;
  wire sync_hit = sync_in | sync_sw;
  wire sync_ld = sync_en & sync_hit;
  assign pre_lim = ~({DIVW{1'b1}} << prescale);
  wire tick = running && (pre_q == pre_lim);
  wire adv = tick && !sync_ld;
  wire at_zero = adv && (nxt == '0);
  wire copy_shd = at_zero && (ld_mode == L_ZERO || (ld_mode == L_ONCE && arm_q));

  always_comb begin
    nxt = cnt_q;
    nxt_up = up_q;
    case (mode)
      M_UP: begin
        nxt_up = 1'b1;
        nxt = (cnt_q >= per_q) ? '0 : cnt_q + CW'(1);
      end
      M_DN: begin
        nxt_up = 1'b0;
        nxt = (cnt_q == '0) ? per_q : cnt_q - CW'(1);
      end
      M_UD: begin
        if (per_q == '0) nxt = '0;
        else if (up_q) begin
          if (cnt_q >= per_q) begin
            nxt = cnt_q - CW'(1);
            nxt_up = 1'b0;
          end else nxt = cnt_q + CW'(1);
        end else if (cnt_q == '0) begin
          nxt = CW'(1);
          nxt_up = 1'b1;
        end else nxt = cnt_q - CW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (sync_ld) pre_q <= '0;
    else if (running) pre_q <= tick ? '0 : pre_q + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q <= 1'b1;
      zev_q <= 1'b0;
      pev_q <= 1'b0;
    end else begin
      zev_q <= at_zero;
      pev_q <= adv && (nxt == per_q);
      if (sync_ld) begin
        cnt_q <= phase;
        if (mode == M_UD) up_q <= sync_dir;
      end else if (adv) begin
        cnt_q <= nxt;
        up_q <= nxt_up;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= RESET_PERIOD;
      shd_q <= RESET_PERIOD;
      arm_q <= 1'b0;
    end else begin
      if (prd_wr) shd_q <= prd_data;
      if (prd_wr && ld_mode == L_IMM) per_q <= prd_data;
      else if (copy_shd) per_q <= shd_q;
      if (oneshot_arm) arm_q <= 1'b1;
      else if (at_zero && ld_mode == L_ONCE) arm_q <= 1'b0;
    end
  end

  always_comb begin
    case (sync_sel)
      2'd1: sync_out = sync_hit;
      2'd2: sync_out = zev_q;
      2'd3: sync_out = pev_q;
      default: sync_out = 1'b0;
    endcase
  end

  assign count = cnt_q;
  assign dir_up = up_q;
  assign zero_evt = zev_q;
  assign prd_evt = pev_q;

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UP && adv && cnt_q < per_q) |=> cnt_q == $past(cnt_q) + CW'(1)); // R2
  AST_ZERO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    zev_q |-> cnt_q == '0); // R2
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DN && adv && cnt_q == '0) |=> cnt_q == $past(per_q)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sync_ld) |=> $stable(cnt_q)); // R5
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ld |=> cnt_q == $past(phase)); // R6
  AST_SYNC_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ld && mode == M_UD) |=> up_q == $past(sync_dir)); // R7
endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
  localparam int CW = 16;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, prd_wr, oneshot_arm, sync_en, sync_in, sync_sw, sync_dir;
  logic [1:0] mode, ld_mode, sync_sel;
  logic [2:0] prescale;
  logic [CW-1:0] prd_data, phase, count;
  logic dir_up, zero_evt, prd_evt, sync_out;
  int checks = 0, errors = 0;

  pwm_timebase u_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .mode(mode), .prescale(prescale), .prd_wr(prd_wr),
    .prd_data(prd_data), .ld_mode(ld_mode), .oneshot_arm(oneshot_arm),
    .sync_en(sync_en), .sync_in(sync_in), .sync_sw(sync_sw), .phase(phase),
    .sync_dir(sync_dir), .sync_sel(sync_sel), .count(count), .dir_up(dir_up),
    .zero_evt(zero_evt), .prd_evt(prd_evt), .sync_out(sync_out));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int per);
    rst_n = 1'b0; mode = 2'd3; prescale = '0; prd_wr = 1'b0; prd_data = '0;
    ld_mode = 2'd0; oneshot_arm = 1'b0; sync_en = 1'b0; sync_in = 1'b0;
    sync_sw = 1'b0; phase = '0; sync_dir = 1'b0; sync_sel = 2'd0;
    step(2);
    rst_n = 1'b1;
    step(1);
    prd_wr = 1'b1; prd_data = CW'(per);
    step(1);
    prd_wr = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; mode = 2'd3; prescale = '0; prd_wr = 1'b0; ld_mode = 2'd0;
    oneshot_arm = 1'b0; sync_en = 1'b0; sync_in = 1'b0; sync_sw = 1'b0;
    sync_sel = 2'd2; phase = '0; sync_dir = 1'b0; prd_data = '0;
    step(2);
    rst_n = 1'b1;
    step(3);
    chk("R1 count", count, 0);
    chk("R1 dir_up", dir_up, 1);
    chk("R1 zero_evt", zero_evt, 0);
    chk("R1 prd_evt", prd_evt, 0);
    chk("R1 sync_out", sync_out, 0);
  endtask

  task automatic test_up();
    setup(4);
    mode = 2'd0;
    for (int k = 1; k <= 10; k++) begin
      step(1);
      chk("R2 up count", count, k % 5);
      chk("R2 zero_evt", zero_evt, int'(k % 5 == 0));
      chk("R2 prd_evt", prd_evt, int'(k % 5 == 4));
    end
  endtask

  task automatic test_down();
    setup(4);
    mode = 2'd1;
    for (int k = 1; k <= 10; k++) begin
      step(1);
      chk("R3 down count", count, (5 - (k % 5)) % 5);
      chk("R3 dir_up", dir_up, 0);
    end
  endtask

  task automatic test_updown();
    setup(4);
    mode = 2'd2;
    for (int k = 1; k <= 16; k++) begin
      step(1);
      chk("R4 triangle count", count, (k % 8 <= 4) ? k % 8 : 8 - k % 8);
      chk("R4 dir_up", dir_up, int'(k % 8 >= 1 && k % 8 <= 4));
      chk("R4 zero_evt", zero_evt, int'(k % 8 == 0));
    end
  endtask

  task automatic test_prescale();
    setup(100);
    prescale = 3'd2;
    mode = 2'd0;
    for (int n = 1; n <= 12; n++) begin
      step(1);
      chk("R5 divided count", count, n / 4);
    end
  endtask

  task automatic test_sync();
    setup(100);
    mode = 2'd0;
    step(5);
    chk("R6 pre-sync count", count, 5);
    sync_en = 1'b1; phase = 16'd50; sync_in = 1'b1;
    step(1);
    sync_in = 1'b0;
    chk("R6 hw sync load", count, 50);
    step(1);
    chk("R6 after sync", count, 51);
    prescale = 3'd1; sync_sw = 1'b1; phase = 16'd20;
    step(1);
    sync_sw = 1'b0;
    chk("R6 sw sync load", count, 20);
    step(1);
    chk("R6 prescaler restart hold", count, 20);
    step(1);
    chk("R6 prescaler restart step", count, 21);
    prescale = 3'd0; sync_en = 1'b0; sync_in = 1'b1; phase = 16'd7;
    step(1);
    sync_in = 1'b0;
    chk("R13 disabled sync ignored", count, 22);
  endtask

  task automatic test_sync_dir();
    setup(100);
    mode = 2'd2;
    step(3);
    sync_en = 1'b1; phase = 16'd30; sync_dir = 1'b0; sync_in = 1'b1;
    step(1);
    sync_in = 1'b0;
    chk("R7 load down", count, 30);
    chk("R7 dir down", dir_up, 0);
    step(1);
    chk("R7 count down", count, 29);
    sync_dir = 1'b1; sync_sw = 1'b1; phase = 16'd60;
    step(1);
    sync_sw = 1'b0;
    chk("R7 dir up", dir_up, 1);
    step(1);
    chk("R7 count up", count, 61);
  endtask

  task automatic test_syncout();
    setup(2);
    sync_in = 1'b1;
    #1 chk("R8 sel0 low", sync_out, 0);
    sync_sel = 2'd1;
    #1 chk("R8 pass hw", sync_out, 1);
    sync_in = 1'b0;
    #1 chk("R8 pass idle", sync_out, 0);
    sync_sw = 1'b1;
    #1 chk("R8 pass sw", sync_out, 1);
    sync_sw = 1'b0;
    sync_sel = 2'd2; mode = 2'd0;
    for (int k = 1; k <= 6; k++) begin
      step(1);
      chk("R8 zero select", sync_out, int'(k % 3 == 0));
    end
    sync_sel = 2'd3;
    for (int k = 7; k <= 12; k++) begin
      step(1);
      chk("R8 period select", sync_out, int'(k % 3 == 2));
    end
  endtask

  task automatic test_ld_imm();
    setup(10);
    mode = 2'd0;
    step(3);
    prd_wr = 1'b1; prd_data = 16'd5;
    step(1);
    prd_wr = 1'b0;
    step(1);
    chk("R9 reach new period", count, 5);
    step(1);
    chk("R9 wrap at new period", count, 0);
  endtask

  task automatic test_ld_zero();
    setup(4);
    ld_mode = 2'd1; mode = 2'd0;
    step(1);
    prd_wr = 1'b1; prd_data = 16'd7;
    step(1);
    prd_wr = 1'b0;
    step(2);
    chk("R10 old period top", count, 4);
    step(1);
    chk("R10 old period wrap", count, 0);
    step(7);
    chk("R10 new period top", count, 7);
    step(1);
    chk("R10 new period wrap", count, 0);
  endtask

  task automatic test_oneshot();
    setup(4);
    ld_mode = 2'd2; prd_wr = 1'b1; prd_data = 16'd7;
    step(1);
    prd_wr = 1'b0; mode = 2'd0;
    step(4);
    chk("R11 unarmed top", count, 4);
    step(1);
    chk("R11 unarmed wrap", count, 0);
    step(5);
    chk("R11 unarmed second wrap", count, 0);
    oneshot_arm = 1'b1;
    step(1);
    oneshot_arm = 1'b0;
    step(4);
    chk("R11 armed wrap", count, 0);
    step(7);
    chk("R11 loaded top", count, 7);
    step(1);
    chk("R11 loaded wrap", count, 0);
    prd_wr = 1'b1; prd_data = 16'd9;
    step(1);
    prd_wr = 1'b0;
    step(6);
    chk("R11 disarmed top", count, 7);
    step(1);
    chk("R11 disarmed wrap", count, 0);
  endtask

  task automatic test_frozen();
    setup(4);
    ld_mode = 2'd3; prd_wr = 1'b1; prd_data = 16'd9;
    step(1);
    prd_wr = 1'b0; mode = 2'd0;
    step(4);
    chk("R12 frozen top", count, 4);
    step(1);
    chk("R12 frozen wrap", count, 0);
    step(5);
    chk("R12 frozen second wrap", count, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_up();
    test_down();
    test_updown();
    test_prescale();
    test_sync();
    test_sync_dir();
    test_syncout();
    test_ld_imm();
    test_ld_zero();
    test_oneshot();
    test_frozen();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule